// File: doc/BRIEF.md
# Signed Leading-Bit Normalizer

This block takes a signed two's-complement word and produces a normalized unsigned magnitude, the sign of the original value, and the number of left shifts that were needed to bring the magnitude's leading one into the top bit position. It is used ahead of a floating-point packer or a block-scaling stage: the shift count acts as the exponent correction and the normalized magnitude as the mantissa. Negative values are first turned into their absolute value, so leading-zero detection works on an unsigned number and never has to look for runs of sign bits.

Normalization uses a cascade of shift stages with power-of-two distances, largest first. A stage moves its word left only when every bit it would push out is zero, fills the freed low positions with zeros, and contributes one bit to the shift count. An all-zero magnitude runs through every stage, so it gives the largest count the field can hold; a separate flag marks that case. A parameter inserts one output register that captures all results together with a delayed valid strobe.

Top module: `signed_normalizer`

## Requirements
- R1: `outSign` equals bit 15 (the two's-complement sign bit) of the `inData` word that produced the result.
- R2: The magnitude is the absolute value of `inData` taken as 16-bit two's complement, and `outMag` equals that magnitude shifted left by `outShift`, with zeros entering at the least significant end.
- R3: `outShift` equals the number of leading zero bits of the magnitude; bit 3 of the count is the 8-position stage, bit 2 the 4-position stage, bit 1 the 2-position stage and bit 0 the 1-position stage.
- R4: Whenever a result is valid and `outZero` is 0, bit 15 of `outMag` is 1.
- R5: An input of zero gives `outZero` = 1, `outShift` = 15 and `outMag` = 0.
- R6: The most negative input 0x8000 gives `outSign` = 1, `outMag` = 0x8000, `outShift` = 0 and `outZero` = 0.
- R7: With the output register enabled (default), `outValid` rises in the clock cycle after a cycle with `inValid` high, and results appear together with it; back-to-back strobes give back-to-back results. Without the register the outputs follow the input in the same cycle.
- R8: With the output register enabled, all result outputs keep their last values in any cycle that follows a cycle without `inValid`.
- R9: During and after reset, before any strobe, `outValid` is 0 and all result outputs are 0.
- R10: The input 0xFFFF (minus one) gives `outMag` = 0x8000, `outShift` = 15, `outSign` = 1 and `outZero` = 0, distinct from the zero case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks `inData` as a word to normalize |
| inData | input | 16 | Two's-complement input word |
| outValid | output | 1 | Marks the result outputs as valid |
| outMag | output | 16 | Normalized unsigned magnitude |
| outSign | output | 1 | Sign of the input word |
| outShift | output | 4 | Left shift applied, equal to the leading-zero count |
| outZero | output | 1 | High when the magnitude is zero |

## Verification
The hardest corner is telling the all-zero input apart from minus one and from a magnitude of one, since all three drive every shift stage to move and yield a count of 15; only the zero flag and the magnitude bit separate them. The stimulus therefore sends 0, 1 and 0xFFFF next to each other, plus 0x8000 whose magnitude only fits because the path is a full 16 bits wide. Walking single bits of both signs reach every count value, a pseudo-random stream with idle gaps exercises the hold behaviour, and back-to-back strobes exercise the register timing.

// File: rtl/snorm_pkg.sv
package snorm_pkg;
  // Strobes sent from control to datapath.
  typedef struct packed {
    logic load;   // capture a new result into the output stage
  } snorm_strobe_t;
endpackage

// File: rtl/snorm_ctrl.sv
module snorm_ctrl
  import snorm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output snorm_strobe_t strobe,
  output logic          outValid
);

  assign strobe.load = inValid;

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid); // R7
      AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid); // R7
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/snorm_datapath.sv
module snorm_datapath
  import snorm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  snorm_strobe_t     strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outMag,
  output logic              outSign,
  output logic [CNT_W-1:0]  outShift,
  output logic              outZero
);

  logic              signBit;
  logic [DATA_W-1:0] magnitude;
  logic [CNT_W:0][DATA_W-1:0] stageWord;
  logic [CNT_W-1:0]  shiftBits;
  logic              isZero;

  // Sign-magnitude conversion: the sign stays outside the shifter.
  assign signBit   = inData[DATA_W-1];
  assign magnitude = signBit ? (~inData + 1'b1) : inData;
  assign isZero    = ~|magnitude;
  assign stageWord[0] = magnitude;

  // Shift cascade, largest distance first; each stage sets one count bit.
  generate
    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
      localparam int BITPOS = CNT_W - 1 - i;
      localparam int DIST   = 1 << BITPOS;
      assign shiftBits[BITPOS] = ~|stageWord[i][DATA_W-1 -: DIST];
      assign stageWord[i+1] = shiftBits[BITPOS]
                            ? {stageWord[i][DATA_W-1-DIST:0], {DIST{1'b0}}}
                            : stageWord[i];
    end
  endgenerate

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outMag   <= '0;
          outSign  <= 1'b0;
          outShift <= '0;
          outZero  <= 1'b0;
        end else if (strobe.load) begin
          outMag   <= stageWord[CNT_W];
          outSign  <= signBit;
          outShift <= shiftBits;
          outZero  <= isZero;
        end
      end

      AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rstN)
        strobe.load |=> (outSign == $past(inData[DATA_W-1]))); // R1
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.load |=> ($stable(outMag) && $stable(outShift)
                          && $stable(outSign) && $stable(outZero))); // R8
    end else begin : g_comb
      assign outMag   = stageWord[CNT_W];
      assign outSign  = signBit;
      assign outShift = shiftBits;
      assign outZero  = isZero;
    end
  endgenerate

endmodule

// File: rtl/signed_normalizer.sv
module signed_normalizer
  import snorm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outMag,
  output logic              outSign,
  output logic [CNT_W-1:0]  outShift,
  output logic              outZero
);

  snorm_strobe_t strobe;

  snorm_ctrl #(.REG_OUT(REG_OUT)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  snorm_datapath #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .outMag   (outMag),
    .outSign  (outSign),
    .outShift (outShift),
    .outZero  (outZero)
  );

  AST_NORM_MSB: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outZero) |-> outMag[DATA_W-1]); // R4
  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outZero) |-> ((outShift == '1) && (outMag == '0))); // R5

endmodule

// File: tb/tb_signed_normalizer.sv
module tb_signed_normalizer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        outValid;
  logic [15:0] outMag;
  logic        outSign;
  logic [3:0]  outShift;
  logic        outZero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [15:0] mag;
    logic        sgn;
    logic [3:0]  sh;
    logic        zr;
    logic [15:0] src;
  } exp_t;

  exp_t expQ[$];
  exp_t lastExp = '0;

  always #10 clk = ~clk;  // 50 MHz

  signed_normalizer dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outMag(outMag), .outSign(outSign),
    .outShift(outShift), .outZero(outZero)
  );

  function automatic exp_t model(input logic [15:0] d);
    exp_t e;
    logic [15:0] m;
    int lz;
    m  = d[15] ? (16'd0 - d) : d;
    lz = 0;
    for (int b = 15; b >= 0; b--) begin
      if (m[b]) break;
      lz++;
    end
    if (m == 16'd0) lz = 15;
    e.mag = m << lz;
    e.sgn = d[15];
    e.sh  = lz[3:0];
    e.zr  = (m == 16'd0);
    e.src = d;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Driver: one word per cycle, expected result pushed into the queue.
  task automatic send(input logic [15:0] d);
    @(negedge clk);
    inValid = 1'b1;
    inData  = d;
    expQ.push_back(model(d));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData  = 16'hA5A5;
    end
  endtask

  // Monitor: samples 5 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rstN) begin
        if (outValid) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R7", "valid without pending input", 1, 0);
          end else begin
            exp_t e;
            e = expQ.pop_front();
            check(outSign == e.sgn, "R1", "sign", outSign, e.sgn);
            check(outMag == e.mag, "R2", "normalized magnitude", outMag, e.mag);
            check(outShift == e.sh, "R3", "shift count", outShift, e.sh);
            check(outZero == e.zr, "R5", "zero flag", outZero, e.zr);
            if (!outZero)
              check(outMag[15], "R4", "msb set on nonzero", outMag, e.mag);
            if (e.src == 16'h8000)
              check(outMag == 16'h8000 && outShift == 4'd0, "R6",
                    "most negative", {outMag, 12'd0, outShift}, 32'h80000000);
            if (e.src == 16'hFFFF)
              check(outMag == 16'h8000 && outShift == 4'hF && !outZero, "R10",
                    "minus one", {outMag, 11'd0, outZero, outShift}, 32'h8000000F);
            lastExp = e;
          end
        end else begin
          check(expQ.size() == 0, "R7", "missing valid", 0, 1);
          check(outMag == lastExp.mag && outShift == lastExp.sh &&
                outSign == lastExp.sgn && outZero == lastExp.zr, "R8",
                "hold while idle", {outMag, 10'd0, outSign, outZero, outShift},
                {lastExp.mag, 10'd0, lastExp.sgn, lastExp.zr, lastExp.sh});
        end
      end
    end
  end

  initial begin
    logic [15:0] lcg;
    repeat (3) @(posedge clk);
    #5;
    // R9: reset state
    check(outValid == 1'b0, "R9", "valid in reset", outValid, 0);
    check(outMag == 0 && outShift == 0 && !outSign && !outZero, "R9",
          "outputs in reset", {outMag, outShift}, 0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);
    // Corner values: zero, one, minus one, extremes
    send(16'h0000); send(16'h0001); send(16'hFFFF); send(16'h0000);
    idle(2);
    send(16'h8000); idle(1);
    send(16'h7FFF); send(16'h8001); send(16'h0100); send(16'hFF00);
    idle(3);
    // Walking single bits, positive and negated
    for (int b = 0; b < 15; b++) begin
      send(16'd1 << b);
      send(16'd0 - (16'd1 << b));
    end
    idle(2);
    // Pseudo-random stream with gaps
    lcg = 16'h1D2B;
    for (int n = 0; n < 300; n++) begin
      lcg = lcg * 16'd25173 + 16'd13849;
      send(lcg >> (lcg[3:0] & 4'hB));
      if (lcg[7:6] == 2'b00) idle(1 + lcg[9:8]);
    end
    idle(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule